// File: doc/BRIEF.md
# Byte-Stream OR Instruction Decoder and Executor

This block accepts an instruction stream one byte per cycle (each byte qualified by `in_valid`). It recognises the register and immediate forms of the 64-bit-mode bitwise inclusive OR instruction, including their prefixes. It reads its operands from an internal file of sixteen 64-bit general registers, writes the result back and updates a small status-flag register. The stream can carry these parts:

- operand-size, lock and REX prefixes;
- one opcode;
- an optional register-addressing byte (ModRM);
- a little-endian immediate of 1, 2 or 4 bytes.

Decoding is variable-length. The operand size follows the prefixes. Immediates are sign-extended to the operand size. 8-bit register codes are remapped depending on whether a REX prefix was seen. Three kinds of stream are rejected with a one-cycle indication and no write:

- a memory-addressed form;
- a byte that is not part of an OR encoding;
- a lock prefix on a register destination.

A host or a test sequencer feeds complete instructions. It observes the results through a combinational register read port and the flag outputs.

Top module: `or_exec_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register, the flags and all event outputs are cleared; after reset all sixteen registers read zero and `flags` reads 0.
- R2: Opcode 0x0C ORs a 1-byte immediate into the low byte of register 0. Opcode 0x0D ORs a 2-byte or 4-byte immediate (lowest byte first) into register 0 at the current operand size.
- R3: Opcodes 0x80, 0x81 and 0x83 are OR only when ModRM bits 5:3 equal 1. Otherwise `not_or` pulses after the ModRM byte and nothing is written. 0x80 takes 1 immediate byte, 0x81 takes 2 or 4, and 0x83 takes 1 byte that is sign-extended to the operand size.
- R4: Opcodes 0x08/0x09 write the r/m register (ModRM bits 2:0) with r/m OR reg. Opcodes 0x0A/0x0B write the reg register (ModRM bits 5:3) with reg OR r/m. 0x08/0x0A are 8-bit and 0x09/0x0B use the operand size.
- R5: The operand size is 32 bits by default. Prefix 0x66 selects 16 bits. A REX byte with bit 3 set selects 64 bits and takes precedence over 0x66. At 64 bits a 4-byte immediate is sign-extended.
- R6: A 32-bit result clears destination bits 63:32. 8-bit and 16-bit results leave all other destination bits unchanged.
- R7: A REX byte (0x40 to 0x4F) counts only when it directly precedes the opcode. Its bit 2 extends the reg field and its bit 0 extends the r/m field to reach registers 8 to 15.
- R8: For 8-bit operands, codes 4 to 7 select bits 15:8 of registers 0, 1, 2, 3 when no REX byte is present, and the low byte of registers 4 to 7 when one is present.
- R9: `flags` bit 0 is the carry flag, bit 1 parity, bit 2 adjust, bit 3 zero, bit 4 sign and bit 5 overflow. After a completed OR:
  - carry and overflow are 0;
  - sign is the most significant bit of the sized result;
  - zero is set when the sized result is zero;
  - parity is set when result bits 7:0 hold an even number of ones;
  - the adjust bit keeps its value.
- R10: A lock prefix (0xF0) on a register-destination OR makes `ud_fault` pulse together with `done`. No register or flag changes.
- R11: A ModRM byte with bits 7:6 not equal to 3 makes `mem_unsupported` pulse in the next cycle. Nothing is written, and decoding restarts at the next byte.
- R12: A byte in the prefix/opcode position that is neither a recognised prefix nor an OR opcode makes `not_or` pulse in the next cycle. Nothing is written.
- R13: `done` is high for exactly the cycle after the last byte of an OR instruction is accepted. The written register and the flags change at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| rd_sel | input | 4 | Register index for the read port |
| rd_data | output | 64 | Current value of register `rd_sel` |
| flags | output | 6 | Status flags (bit positions per R9) |
| done | output | 1 | OR instruction completed (one cycle) |
| ud_fault | output | 1 | Invalid-opcode fault for a locked register form |
| not_or | output | 1 | Stream byte is not part of an OR encoding |
| mem_unsupported | output | 1 | Memory-addressed ModRM rejected |

## Verification
The assertions assume a well-formed stream. After `not_or` or `mem_unsupported`, the host sends no leftover displacement or immediate bytes, and `in_valid` is never unknown once reset is released. Under those assumptions, at most one of the three outcome pulses appears in a cycle, and registers hold whenever no write is issued. The stimulus sends only complete instructions, or streams that end exactly at the rejected byte. It leaves several idle cycles between them, so every outcome pulse and its write-back can be tied to a single instruction.

// File: rtl/or_pkg.sv
`timescale 1ns/100ps
// Package: shared sizes, operand-size encoding, flag bit positions and the
// execution record handed from the decoder to the execute stage.
package or_pkg;
    parameter int XLEN  = 64;
    parameter int NREGS = 16;
    localparam int RIDX_W = $clog2(NREGS);
    localparam int NFLAGS = 6;

    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_AF = 2;
    localparam int FL_ZF = 3;
    localparam int FL_SF = 4;
    localparam int FL_OF = 5;

    typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} opsz_e;

    typedef struct packed {
        opsz_e             sz;
        logic [RIDX_W-1:0] dst_idx;
        logic              dst_hi;
        logic              use_imm;
        logic [RIDX_W-1:0] src_idx;
        logic              src_hi;
        logic [XLEN-1:0]   imm;
        logic              lock;
    } exec_rec_t;
endpackage

// File: rtl/or_decode.sv
`timescale 1ns/100ps
// Module: or_decode
// Walks the byte stream (prefixes, opcode, ModRM, immediate) and, on the last
// byte of a register-form OR, registers an execution record with ex_valid.
// Rejections (not_or, mem_unsup) pulse one cycle after the offending byte.
// Assumes the host sends no leftover bytes after a rejection.
module or_decode
    import or_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic [7:0] in_byte,
    output logic      ex_valid,
    output exec_rec_t ex_rec,
    output logic      not_or,
    output logic      mem_unsup
);
    typedef enum logic [1:0] {ST_PFX, ST_MODRM, ST_IMM} dec_st_e;

    dec_st_e     st_q;
    logic        osz_q, lock_q, rex_on_q;
    logic [2:0]  rex_q;          // {W, R, B}
    logic [7:0]  opc_q, modrm_q;
    logic [31:0] imm_q;
    logic [2:0]  cnt_q;

    function automatic logic is_pfx(input logic [7:0] b);
        return (b == 8'h66) || (b == 8'hF0) || (b[7:4] == 4'h4);
    endfunction

    function automatic logic is_or_op(input logic [7:0] b);
        return (b == 8'h08) || (b == 8'h09) || (b == 8'h0A) || (b == 8'h0B) ||
               (b == 8'h0C) || (b == 8'h0D) || (b == 8'h80) || (b == 8'h81) ||
               (b == 8'h83);
    endfunction

    function automatic opsz_e size_of(input logic [7:0] op, input logic w, input logic o16);
        if (op == 8'h08 || op == 8'h0A || op == 8'h0C || op == 8'h80) return SZ8;
        if (w)   return SZ64;
        if (o16) return SZ16;
        return SZ32;
    endfunction

    function automatic logic [2:0] imm_len(input logic [7:0] op, input opsz_e sz);
        if (op == 8'h0C || op == 8'h80 || op == 8'h83) return 3'd1;
        if (op == 8'h0D || op == 8'h81) return (sz == SZ16) ? 3'd2 : 3'd4;
        return 3'd0;
    endfunction

    // returns {hi_byte, index}
    function automatic logic [RIDX_W:0] map_reg(input logic ext, input logic [2:0] code,
                                                input logic byte_op, input logic rex_seen);
        if (byte_op && !rex_seen && code[2]) return {1'b1, RIDX_W'(code[1:0])};
        return {1'b0, RIDX_W'({ext, code})};
    endfunction

    opsz_e          sz_c;
    logic [2:0]     len_c;
    logic [7:0]     mrm_c;
    logic [31:0]    imm_c;
    logic [XLEN-1:0] imm_x;
    logic [RIDX_W:0] regf_c, rmf_c;
    exec_rec_t      rec_c;
    logic           ev_fin, ev_nor, ev_mem;

    // Purpose: operand size, immediate assembly and the execution record.
    always_comb begin
        sz_c   = size_of(opc_q, rex_q[2], osz_q);
        len_c  = imm_len(opc_q, sz_c);
        mrm_c  = (st_q == ST_MODRM) ? in_byte : modrm_q;
        imm_c  = imm_q | (32'(in_byte) << {cnt_q, 3'b000});
        case (len_c)
            3'd1:    imm_x = {{(XLEN-8){imm_c[7]}}, imm_c[7:0]};
            3'd2:    imm_x = {{(XLEN-16){imm_c[15]}}, imm_c[15:0]};
            default: imm_x = {{(XLEN-32){imm_c[31]}}, imm_c};
        endcase
        regf_c = map_reg(rex_q[1], mrm_c[5:3], sz_c == SZ8, rex_on_q);
        rmf_c  = map_reg(rex_q[0], mrm_c[2:0], sz_c == SZ8, rex_on_q);
        rec_c         = '0;
        rec_c.sz      = sz_c;
        rec_c.imm     = imm_x;
        rec_c.lock    = lock_q;
        rec_c.use_imm = (opc_q == 8'h0C) || (opc_q == 8'h0D) || opc_q[7];
        if (opc_q == 8'h0C || opc_q == 8'h0D) begin
            rec_c.dst_idx = '0;
        end else if (opc_q == 8'h0A || opc_q == 8'h0B) begin
            {rec_c.dst_hi, rec_c.dst_idx} = regf_c;
            {rec_c.src_hi, rec_c.src_idx} = rmf_c;
        end else begin
            {rec_c.dst_hi, rec_c.dst_idx} = rmf_c;
            {rec_c.src_hi, rec_c.src_idx} = regf_c;
        end
    end

    // Purpose: classify the current byte as completing, rejecting or neither.
    always_comb begin
        ev_fin = 1'b0;
        ev_nor = 1'b0;
        ev_mem = 1'b0;
        if (in_valid) begin
            case (st_q)
                ST_PFX:   ev_nor = !is_pfx(in_byte) && !is_or_op(in_byte);
                ST_MODRM: begin
                    if (in_byte[7:6] != 2'b11)                   ev_mem = 1'b1;
                    else if (opc_q[7] && in_byte[5:3] != 3'd1)   ev_nor = 1'b1;
                    else if (len_c == 3'd0)                      ev_fin = 1'b1;
                end
                ST_IMM:   ev_fin = (cnt_q + 3'd1) == len_c;
                default:  ;
            endcase
        end
    end

    // Purpose: decode state, prefix capture and registered outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_PFX;  osz_q <= 1'b0; lock_q <= 1'b0; rex_on_q <= 1'b0;
            rex_q <= '0; opc_q <= '0; modrm_q <= '0; imm_q <= '0; cnt_q <= '0;
            ex_valid <= 1'b0; not_or <= 1'b0; mem_unsup <= 1'b0; ex_rec <= '0;
        end else begin
            ex_valid  <= ev_fin;
            not_or    <= ev_nor;
            mem_unsup <= ev_mem;
            if (ev_fin) ex_rec <= rec_c;
            if (ev_fin || ev_nor || ev_mem) begin
                st_q <= ST_PFX;  osz_q <= 1'b0; lock_q <= 1'b0; rex_on_q <= 1'b0;
                rex_q <= '0; imm_q <= '0; cnt_q <= '0;
            end else if (in_valid) begin
                case (st_q)
                    ST_PFX: begin
                        if (in_byte == 8'h66) begin
                            osz_q <= 1'b1; rex_on_q <= 1'b0; rex_q <= '0;
                        end else if (in_byte == 8'hF0) begin
                            lock_q <= 1'b1; rex_on_q <= 1'b0; rex_q <= '0;
                        end else if (in_byte[7:4] == 4'h4) begin
                            rex_on_q <= 1'b1; rex_q <= {in_byte[3], in_byte[2], in_byte[0]};
                        end else begin
                            opc_q <= in_byte;
                            st_q  <= (in_byte == 8'h0C || in_byte == 8'h0D) ? ST_IMM : ST_MODRM;
                        end
                    end
                    ST_MODRM: begin
                        modrm_q <= in_byte;
                        st_q    <= ST_IMM;
                    end
                    ST_IMM: begin
                        imm_q <= imm_c;
                        cnt_q <= cnt_q + 3'd1;
                    end
                    default: st_q <= ST_PFX;
                endcase
            end
        end
    end

    // R12/R11/R3: one instruction ends in at most one outcome per cycle
    a_r12_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ex_valid, not_or, mem_unsup}));
endmodule

// File: rtl/or_regfile.sv
`timescale 1ns/100ps
// Module: or_regfile
// General register file: two combinational operand reads, one debug read and
// one synchronous write. Assumes a single writer.
module or_regfile #(
    parameter int N = 16,
    parameter int W = 64,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b,
    input  logic [AW-1:0] ra_c,
    output logic [W-1:0]  rd_c
);
    logic [N-1:0][W-1:0] regs;

    // Purpose: reset clears, otherwise one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  regs <= '0;
        else if (we) regs[waddr] <= wdata;
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];

    // R11/R10/R3: no write issued means no register moves
    a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs));
endmodule

// File: rtl/or_alu.sv
`timescale 1ns/100ps
// Module: or_alu
// Sized OR of two operands (optionally from bits 15:8), destination merge and
// result flags. Purely combinational.
module or_alu
    import or_pkg::*;
(
    input  opsz_e           sz,
    input  logic [XLEN-1:0] dst_val,
    input  logic            dst_hi,
    input  logic [XLEN-1:0] src_val,
    input  logic            src_hi,
    input  logic            use_imm,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] wr_val,
    output logic            sf,
    output logic            zf,
    output logic            pf
);
    logic [XLEN-1:0] a, b, r, rs;

    // Purpose: select operands, size the result, merge and derive flags.
    always_comb begin
        a  = dst_hi ? XLEN'(dst_val[15:8]) : dst_val;
        b  = use_imm ? imm : (src_hi ? XLEN'(src_val[15:8]) : src_val);
        r  = a | b;
        case (sz)
            SZ8: begin
                rs     = XLEN'(r[7:0]);
                sf     = r[7];
                wr_val = dst_hi ? {dst_val[XLEN-1:16], r[7:0], dst_val[7:0]}
                                : {dst_val[XLEN-1:8], r[7:0]};
            end
            SZ16: begin
                rs     = XLEN'(r[15:0]);
                sf     = r[15];
                wr_val = {dst_val[XLEN-1:16], r[15:0]};
            end
            SZ32: begin
                rs     = XLEN'(r[31:0]);
                sf     = r[31];
                wr_val = XLEN'(r[31:0]);
            end
            default: begin
                rs     = r;
                sf     = r[XLEN-1];
                wr_val = r;
            end
        endcase
        zf = (rs == '0);
        pf = ~^rs[7:0];
    end
endmodule

// File: rtl/or_exec_unit.sv
`timescale 1ns/100ps
// Module: or_exec_unit (top)
// Decodes register-form OR instructions from a byte stream and executes them
// in the cycle done is high: operands are read then, the write lands at the
// end of that cycle. Assumes complete instructions and no leftover bytes.
module or_exec_unit
    import or_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [RIDX_W-1:0] rd_sel,
    output logic [XLEN-1:0]   rd_data,
    output logic [NFLAGS-1:0] flags,
    output logic              done,
    output logic              ud_fault,
    output logic              not_or,
    output logic              mem_unsupported
);
    exec_rec_t       rec;
    logic            ex_valid, we, sf, zf, pf;
    logic [XLEN-1:0] dst_val, src_val, wr_val;
    logic [NFLAGS-1:0] flags_q;

    or_decode u_dec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .ex_valid(ex_valid), .ex_rec(rec), .not_or(not_or), .mem_unsup(mem_unsupported)
    );

    or_regfile #(.N(NREGS), .W(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(rec.dst_idx), .wdata(wr_val),
        .ra_a(rec.dst_idx), .rd_a(dst_val), .ra_b(rec.src_idx), .rd_b(src_val),
        .ra_c(rd_sel), .rd_c(rd_data)
    );

    or_alu u_alu (
        .sz(rec.sz), .dst_val(dst_val), .dst_hi(rec.dst_hi), .src_val(src_val),
        .src_hi(rec.src_hi), .use_imm(rec.use_imm), .imm(rec.imm),
        .wr_val(wr_val), .sf(sf), .zf(zf), .pf(pf)
    );

    assign we       = ex_valid && !rec.lock;
    assign done     = ex_valid;
    assign ud_fault = ex_valid && rec.lock;
    assign flags    = flags_q;

    // Purpose: status flag update on each committed OR; adjust bit is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (we) begin
            flags_q[FL_CF] <= 1'b0;
            flags_q[FL_OF] <= 1'b0;
            flags_q[FL_SF] <= sf;
            flags_q[FL_ZF] <= zf;
            flags_q[FL_PF] <= pf;
        end
    end

    // R10: the fault is always reported together with done
    a_r10_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> done);
    // R10: a faulted instruction leaves the flags untouched
    a_r10_fault_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |=> $stable(flags_q));
    // R9: carry and overflow read zero after any committed OR
    a_r9_cf_of_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ud_fault) |=> (!flags_q[FL_CF] && !flags_q[FL_OF]));
endmodule

// File: tb/or_exec_unit_test.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver queues the expected outcome of each stream,
// the monitor pops it on every outcome pulse and checks before/after values.
module or_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [3:0]  rd_sel = 4'd0;
    logic [63:0] rd_data;
    logic [5:0]  flags;
    logic        done, ud_fault, not_or, mem_unsupported;

    or_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .rd_sel(rd_sel), .rd_data(rd_data), .flags(flags), .done(done),
        .ud_fault(ud_fault), .not_or(not_or), .mem_unsupported(mem_unsupported)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          kind;   // 0 done, 1 fault, 2 not_or, 3 memory form
        string       tag;
        int          ridx;
        logic [63:0] pre;
        logic [63:0] post;
        logic [5:0]  flg;
    } exp_t;

    exp_t sbq[$];
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input string tag, input int ridx,
                        input logic [63:0] pre, input logic [63:0] post, input logic [5:0] flg);
        exp_t e;
        e.kind = kind; e.tag = tag; e.ridx = ridx; e.pre = pre; e.post = post; e.flg = flg;
        sbq.push_back(e);
    endtask

    task automatic sb(input logic [7:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = x;
    endtask

    task automatic fin();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: reset checks, then compare every outcome against the queue.
    initial begin
        @(posedge rst_n);
        @(negedge clk);
        #1;
        chk("R1", "outputs after reset", {52'd0, flags, done, ud_fault, not_or, mem_unsupported}, 64'd0);
        for (int i = 0; i < 16; i++) begin
            rd_sel = 4'(i);
            #0.1;
            chk("R1", "register after reset", rd_data, 64'd0);
        end
        forever begin
            @(negedge clk);
            #1;
            if (done || not_or || mem_unsupported) begin
                int k;
                exp_t e;
                k = ud_fault ? 1 : (done ? 0 : (not_or ? 2 : 3));
                if (sbq.size() == 0) begin
                    chk("R13", "unexpected outcome", 64'(k), 64'hFFFF);
                end else begin
                    e = sbq.pop_front();
                    chk(e.tag, "outcome kind", 64'(k), 64'(e.kind));
                    rd_sel = 4'(e.ridx);
                    #1;
                    chk("R13", "register before edge", rd_data, e.pre);
                    @(negedge clk);
                    #1;
                    chk(e.tag, "register after", rd_data, e.post);
                    chk(e.tag, "flags after", 64'(flags), 64'(e.flg));
                end
            end
        end
    end

    // Driver: streams and their expected outcomes.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R2: AL |= 0x5A
        push(0, "R2", 0, 64'h0, 64'h5A, 6'h02);
        sb(8'h0C); sb(8'h5A); fin();
        // R5 default 32-bit, 4-byte immediate into EAX
        push(0, "R5", 0, 64'h5A, 64'h8000_015A, 6'h12);
        sb(8'h0D); sb(8'h00); sb(8'h01); sb(8'h00); sb(8'h80); fin();
        // R7 REX.B reaches r9, 64-bit sign-extended immediate
        push(0, "R7", 9, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 6'h12);
        sb(8'h49); sb(8'h81); sb(8'hC9); sb(8'hF0); sb(8'hFF); sb(8'hFF); sb(8'hFF); fin();
        // R3 0x83 sign-extends at 16 bits into DX
        push(0, "R3", 2, 64'h0, 64'hFF80, 6'h10);
        sb(8'h66); sb(8'h83); sb(8'hCA); sb(8'h80); fin();
        // R5 REX.W 64-bit fill of r3
        push(0, "R5", 3, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 6'h12);
        sb(8'h48); sb(8'h83); sb(8'hCB); sb(8'hFF); fin();
        // R6 32-bit result clears upper half
        push(0, "R6", 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 6'h12);
        sb(8'h83); sb(8'hCB); sb(8'h00); fin();
        // R6 16-bit result keeps upper bits of r9
        push(0, "R6", 9, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF1, 6'h10);
        sb(8'h66); sb(8'h41); sb(8'h83); sb(8'hC9); sb(8'h01); fin();
        // R7 REX not last before opcode is dropped: targets r1
        push(0, "R7", 1, 64'h0, 64'h1, 6'h00);
        sb(8'h41); sb(8'h66); sb(8'h83); sb(8'hC9); sb(8'h01); fin();
        // R4 0x09 writes r/m (EAX)
        push(0, "R4", 0, 64'h8000_015A, 64'h8000_015B, 6'h10);
        sb(8'h09); sb(8'hC8); fin();
        // R4 0x0B writes reg (ECX)
        push(0, "R4", 1, 64'h1, 64'h8000_015B, 6'h10);
        sb(8'h0B); sb(8'hC8); fin();
        // R8 code 4 without REX is bits 15:8 of r0
        push(0, "R8", 0, 64'h8000_015B, 64'h8000_215B, 6'h02);
        sb(8'h80); sb(8'hCC); sb(8'h20); fin();
        // R8 code 4 with REX is low byte of r4
        push(0, "R8", 4, 64'h0, 64'h20, 6'h00);
        sb(8'h40); sb(8'h80); sb(8'hCC); sb(8'h20); fin();
        // R9 zero result sets zero and parity
        push(0, "R9", 5, 64'h0, 64'h0, 6'h0A);
        sb(8'h40); sb(8'h80); sb(8'hCD); sb(8'h00); fin();
        // R5 REX.W beats 0x66: 4-byte immediate, sign-extended
        push(0, "R5", 0, 64'h8000_215B, 64'hFFFF_FFFF_F000_215B, 6'h10);
        sb(8'h66); sb(8'h48); sb(8'h0D); sb(8'h00); sb(8'h00); sb(8'h00); sb(8'hF0); fin();
        // R10 lock on register form faults, no change
        push(1, "R10", 0, 64'hFFFF_FFFF_F000_215B, 64'hFFFF_FFFF_F000_215B, 6'h10);
        sb(8'hF0); sb(8'h0C); sb(8'hFF); fin();
        // R3 group opcode with reg field 0 is not OR
        push(2, "R3", 0, 64'hFFFF_FFFF_F000_215B, 64'hFFFF_FFFF_F000_215B, 6'h10);
        sb(8'h80); sb(8'hC0); fin();
        // R11 memory form rejected
        push(3, "R11", 0, 64'hFFFF_FFFF_F000_215B, 64'hFFFF_FFFF_F000_215B, 6'h10);
        sb(8'h09); sb(8'h00); fin();
        // R12 unrelated opcode
        push(2, "R12", 0, 64'hFFFF_FFFF_F000_215B, 64'hFFFF_FFFF_F000_215B, 6'h10);
        sb(8'h90); fin();
        repeat (6) @(negedge clk);
        chk("R13", "outcomes still pending", 64'(sbq.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule